// File: doc/BRIEF.md
# Delayed Port Interrupt Source

This block produces one interrupt request line for a CPU. Its source is chosen by a select input. In one setting the request simply follows a single dedicated pin. In the other setting the request comes from the OR of an 8-bit input port, and it fires only after the port condition has been held for a programmable number of milliseconds. The millisecond base is a one-cycle tick pulse supplied from outside.

All pin inputs pass through a two-flop synchronizer. The delay is chosen by a 4-bit code held in an 8-bit configuration register. The code map is irregular:

- code 2 gives 2 ms;
- codes 3 to 10 give their own value in ms;
- every other code gives 5 ms.

The port-OR condition must stay true for every tick it counts. If the condition drops, the count starts again from zero.

Top module: `irq_src_delay`

## Requirements
- R1: With `srcSelPort` low, `irqReq` equals the level of `dedPin` delayed by three clock edges (two synchronizer stages plus the output register), and `portPins` has no effect on it.
- R2: With `srcSelPort` high, the source is the OR of all eight `portPins`, so any single pin can fire it. In this setting `dedPin` has no effect on `irqReq`.
- R3: After reset, `cfgRdata` reads 8'h02, which is delay code 2 (2 ms), and `irqReq` is low.
- R4: Delay codes 3 through 10 select a delay equal to the code value in ms.
- R5: Delay codes 0, 1 and 11 through 15 all select 5 ms.
- R6: While `cfgWe` is high, the clock edge stores `cfgWdata[3:0]` as the delay code. Bits 7:4 of `cfgRdata` always read 0, and writes to those bits are ignored.
- R7: In port mode, `irqReq` stays low until N `msTick` pulses have been counted while the synchronized port OR was continuously true, where N is the selected delay. A drop of the OR clears the count.
- R8: `irqReq` rises on the clock edge after the edge that samples the Nth counted tick.
- R9: In port mode, `irqReq` falls on the clock edge after the synchronized port OR goes low. That is three edges after the pins all go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portPins | input | 8 | Port inputs whose OR is the delayed source |
| dedPin | input | 1 | Dedicated interrupt pin |
| srcSelPort | input | 1 | 0: dedicated pin, 1: port OR with delay |
| msTick | input | 1 | One-cycle pulse every millisecond |
| cfgWe | input | 1 | Write strobe for the delay register |
| cfgWdata | input | 8 | Write data; only bits 3:0 are stored |
| cfgRdata | output | 8 | Register contents; bits 7:4 read 0 |
| irqReq | output | 1 | Interrupt request to the CPU |

## Verification
The bench walks all sixteen delay codes. For each code it checks that the request is still low one tick before the delay expires and high right after it. A wrong entry in the code map therefore shows up as an early or late edge. A directed test drops the port part-way through a count and then raises it again. A design that keeps the partial count would fire early on the second attempt, and the bench catches that. Further tests cover writes with the upper register bits set, the dedicated pin in port mode, the port pins in dedicated mode, and the exact edge on which the request falls. These catch a leaking source mux, an unmasked register, and a missing or extra register stage.

// File: rtl/irq_delay_pkg.sv
package irq_delay_pkg;
  localparam int CODE_W = 4;
  localparam int CFG_W = 8;
  localparam logic [CODE_W-1:0] CODE_RESET = CODE_W'(2);
  localparam logic [CODE_W-1:0] CODE_FALLBACK_MS = CODE_W'(5);
  localparam logic [CODE_W-1:0] CODE_LINEAR_LO = CODE_W'(2);
  localparam logic [CODE_W-1:0] CODE_LINEAR_HI = CODE_W'(10);

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } ctlStrobe_t;

  // Map a delay code to milliseconds: codes 2..10 map to themselves,
  // every other code falls back to 5 ms.
  function automatic logic [CODE_W-1:0] codeToMs(input logic [CODE_W-1:0] code);
    if (code >= CODE_LINEAR_LO && code <= CODE_LINEAR_HI) return code;
    return CODE_FALLBACK_MS;
  endfunction
endpackage

// File: rtl/irq_delay_datapath.sv
module irq_delay_datapath
  import irq_delay_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] portPins,
  input  logic              dedPin,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  ctlStrobe_t        strobe,
  output logic              anyPort,
  output logic              dedSync,
  output logic              delayDone,
  output logic [CFG_W-1:0]  cfgRdata
);
  localparam int SYNC_W = PORT_W + 1;
  localparam int CNT_W = CODE_W;

  logic [SYNC_W-1:0] syncChain [SYNC_STAGES];
  logic [CODE_W-1:0] delayCode;
  logic [CNT_W-1:0]  tickCnt;
  logic [CODE_W-1:0] targetMs;
  logic              unusedHi;

  // Pin synchronizer, one register per stage.
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[g] <= '0;
          else       syncChain[g] <= {dedPin, portPins};
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[g] <= '0;
          else       syncChain[g] <= syncChain[g-1];
      end
    end
  endgenerate

  assign anyPort = |syncChain[SYNC_STAGES-1][PORT_W-1:0];
  assign dedSync = syncChain[SYNC_STAGES-1][PORT_W];

  // Delay code register: only the low bits are kept.
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)      delayCode <= CODE_RESET;
    else if (cfgWe) delayCode <= cfgWdata[CODE_W-1:0];

  assign unusedHi = ^cfgWdata[CFG_W-1:CODE_W];
  assign cfgRdata = {{(CFG_W-CODE_W){1'b0}}, delayCode};

  assign targetMs = codeToMs(delayCode);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              tickCnt <= '0;
    else if (strobe.cntClr) tickCnt <= '0;
    else if (strobe.cntInc) tickCnt <= tickCnt + 1'b1;

  assign delayDone = (tickCnt >= targetMs);

  // R6
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> delayCode == $past(cfgWdata[CODE_W-1:0]));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CNT_W'(CODE_LINEAR_HI));

  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> tickCnt == '0);
endmodule

// File: rtl/irq_delay_control.sv
module irq_delay_control
  import irq_delay_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       srcSelPort,
  input  logic       msTick,
  input  logic       anyPort,
  input  logic       dedSync,
  input  logic       delayDone,
  output ctlStrobe_t strobe,
  output logic       irqReq
);
  logic reqQ;

  always_comb begin
    strobe.cntClr = !srcSelPort || !anyPort;
    strobe.cntInc = srcSelPort && anyPort && msTick && !delayDone;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           reqQ <= 1'b0;
    else if (srcSelPort) reqQ <= anyPort && delayDone;
    else                 reqQ <= dedSync;

  assign irqReq = reqQ;

  // R1
  ded_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !srcSelPort |=> irqReq == $past(dedSync));

  // R9
  port_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSelPort && !anyPort) |=> !irqReq);

  // R7
  early_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSelPort && !delayDone) |=> !irqReq);

  // R8
  fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSelPort && anyPort && delayDone) |=> irqReq);
endmodule

// File: rtl/irq_src_delay.sv
module irq_src_delay
  import irq_delay_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] portPins,
  input  logic              dedPin,
  input  logic              srcSelPort,
  input  logic              msTick,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  output logic [CFG_W-1:0]  cfgRdata,
  output logic              irqReq
);
  ctlStrobe_t strobe;
  logic anyPort, dedSync, delayDone;

  irq_delay_datapath #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .portPins(portPins), .dedPin(dedPin),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .strobe(strobe),
    .anyPort(anyPort), .dedSync(dedSync), .delayDone(delayDone),
    .cfgRdata(cfgRdata)
  );

  irq_delay_control uCtl (
    .clk(clk), .rstN(rstN), .srcSelPort(srcSelPort), .msTick(msTick),
    .anyPort(anyPort), .dedSync(dedSync), .delayDone(delayDone),
    .strobe(strobe), .irqReq(irqReq)
  );
endmodule

// File: tb/irq_src_delay_test.sv
module irq_src_delay_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] portPins = '0;
  logic dedPin = 1'b0, srcSelPort = 1'b1, msTick = 1'b0, cfgWe = 1'b0;
  logic [7:0] cfgWdata = '0;
  logic [7:0] cfgRdata;
  logic irqReq;
  int checks = 0, errors = 0;
  bit finished = 0;

  // Expected delay in ms for codes 0..15 (R4, R5).
  localparam int EXP_MS [16] = '{5, 5, 2, 3, 4, 5, 6, 7, 8, 9, 10, 5, 5, 5, 5, 5};
  localparam logic [7:0] PIN_PAT [4] = '{8'h01, 8'h80, 8'h24, 8'hFF};

  irq_src_delay uut (
    .clk(clk), .rstN(rstN), .portPins(portPins), .dedPin(dedPin),
    .srcSelPort(srcSelPort), .msTick(msTick), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .irqReq(irqReq)
  );

  always #2 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrCfg(input logic [7:0] v);
    cfgWe = 1'b1; cfgWdata = v; step(1); cfgWe = 1'b0;
  endtask

  task automatic tick;
    msTick = 1'b1; step(1); msTick = 1'b0; step(1);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    step(3);
    // R3 reset state
    chk("R3 cfg", cfgRdata, 8'h02);
    chk("R3 irq", {7'b0, irqReq}, 8'h00);
    rstN = 1'b1; step(1);

    // Table walk over every code (R4, R5, R7, R8, R9)
    for (int i = 0; i < 16; i++) begin
      wrCfg(8'(i));
      portPins = PIN_PAT[i % 4]; step(3);
      for (int t = 0; t < EXP_MS[i] - 1; t++) tick();
      step(2);
      chk((i >= 3 && i <= 10) ? "R4 early" : "R5 early", {7'b0, irqReq}, 8'h00);
      tick();
      chk((i >= 3 && i <= 10) ? "R4/R8 fire" : "R5/R8 fire", {7'b0, irqReq}, 8'h01);
      portPins = '0; step(3);
      chk("R9 drop", {7'b0, irqReq}, 8'h00);
    end

    // R6 upper bits ignored, lower stored
    wrCfg(8'hF7);
    chk("R6 readback", cfgRdata, 8'h07);
    wrCfg(8'hA3);
    chk("R6 readback2", cfgRdata, 8'h03);

    // R7 restart after a drop (code 5)
    wrCfg(8'h05);
    portPins = 8'h10; step(3);
    repeat (3) tick();
    portPins = '0; step(3);
    portPins = 8'h10; step(3);
    repeat (4) tick();
    step(2);
    chk("R7 restart", {7'b0, irqReq}, 8'h00);
    tick();
    chk("R7 fire", {7'b0, irqReq}, 8'h01);

    // R9 exact fall edge
    portPins = '0; step(2);
    chk("R9 still high", {7'b0, irqReq}, 8'h01);
    step(1);
    chk("R9 low", {7'b0, irqReq}, 8'h00);

    // R2 dedicated pin ignored in port mode
    dedPin = 1'b1; step(6);
    chk("R2 ded ignored", {7'b0, irqReq}, 8'h00);
    dedPin = 1'b0;

    // R1 dedicated mode
    srcSelPort = 1'b0;
    portPins = 8'hFF; step(3);
    repeat (6) tick();
    chk("R1 port ignored", {7'b0, irqReq}, 8'h00);
    dedPin = 1'b1; step(2);
    chk("R1 latency", {7'b0, irqReq}, 8'h00);
    step(1);
    chk("R1 rise", {7'b0, irqReq}, 8'h01);
    dedPin = 1'b0; step(3);
    chk("R1 fall", {7'b0, irqReq}, 8'h00);
    portPins = '0;

    // R3 reset again restores the code
    rstN = 1'b0; step(1);
    chk("R3 re-reset", cfgRdata, 8'h02);
    summary();
  end
endmodule